// File: doc/BRIEF.md
# UART Host Register and Buffer Interface

This block sits between a processor bus and the serial core of a UART. A single data address serves both directions: a write lands in a one-entry transmit holding buffer, and a read returns the oldest entry of a two-entry receive queue. A second address holds the status byte. It carries the receive-ready, transmit-done and holding-buffer-free flags, and the error flags of the character at the head of the receive queue.

On the serial side, the block hands a byte to the transmit shifter through a one-cycle load strobe. It accepts finished characters from the receive shifter as one-cycle valid pulses, each carrying a framing-error bit and a parity-error bit. The three flags also drive three interrupt request lines directly. The character size is set by a 2-bit input that gives the number of data bits: 0 selects 5 bits, 1 selects 6, 2 selects 7 and 3 selects 8. Baud timing, shifting and parity generation live outside the block.

Address 0 is the data address and address 1 is the status address. The status byte is laid out as follows:

- bit 7: receive-ready
- bit 6: transmit-done
- bit 5: holding-buffer-free
- bit 4: framing error
- bit 3: overrun
- bit 2: parity error
- bits 1 and 0: read as 0

Top module: `uart_host_regs`

## Requirements
- R1: A write to address 0 while status bit 5 is 1 stores the byte in the holding buffer and clears bit 5. The stored byte is later the one presented on `txs_data` at the load strobe.
- R2: A write to address 0 while status bit 5 is 0 is dropped, and the holding buffer keeps its earlier byte.
- R3: When `tx_en` is 1, the holding buffer is full and `txs_empty` is 1, `txs_load` is high in that cycle with the buffered byte on `txs_data`, and bit 5 is 1 from the next cycle on. While `tx_en` is 0, no load happens and bit 5 stays 0.
- R4: The receive queue holds two characters and returns them in arrival order. Every read of address 0 removes the head. A read of an empty queue returns 0 and changes nothing.
- R5: Status bit 7 is 1 exactly when the receive queue holds at least one unread character.
- R6: While `rx_en` is 0, the receive queue is emptied and arriving characters are discarded, so bit 7 reads 0.
- R7: Status bit 6 sets on a `txs_done` pulse that arrives while the holding buffer is empty; a pulse that arrives while the buffer is full leaves bit 6 unchanged. If a set and a clear fall in the same cycle, the set wins.
- R8: Status bit 6 clears on a pulse of `irq_txc_ack`, or on a write to address 1 with data bit 6 equal to 1. A write with bit 6 equal to 0 leaves it unchanged.
- R9: After reset the status byte reads 0x20. Writes to address 1 never change bits 7, 5, 4, 3 or 2.
- R10: Data bits at and above the character size are dropped from transmitted bytes and read back as 0 from received bytes.
- R11: Status bits 4 (framing) and 2 (parity) are stored with each received character and show the values of the head entry. They read 0 when the queue is empty.
- R12: A character that arrives while both entries are full and no read happens in that cycle is discarded, and status bit 3 is set on the newer stored entry. If a read and an arrival fall in the same cycle on a full queue, the arriving character is kept.
- R13: `irq_rxc`, `irq_txc` and `irq_udre` follow status bits 7, 6 and 5.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| bus_sel | input | 1 | Bus access strobe, one cycle per access |
| bus_wr | input | 1 | 1 = write, 0 = read |
| bus_addr | input | 1 | 0 = data, 1 = status |
| bus_wdata | input | 8 | Write data |
| bus_rdata | output | 8 | Read data (combinational) |
| tx_en | input | 1 | Transmitter enable |
| rx_en | input | 1 | Receiver enable |
| char_size | input | 2 | Data bits: 0=5, 1=6, 2=7, 3=8 |
| txs_empty | input | 1 | Transmit shifter can take a byte |
| txs_done | input | 1 | Pulse: shifter finished a frame |
| txs_load | output | 1 | Strobe: shifter takes `txs_data` |
| txs_data | output | 8 | Byte handed to the shifter |
| rxs_valid | input | 1 | Pulse: a received character is ready |
| rxs_data | input | 8 | Received character |
| rxs_ferr | input | 1 | Framing error of that character |
| rxs_perr | input | 1 | Parity error of that character |
| irq_txc_ack | input | 1 | Pulse: transmit-done interrupt serviced |
| irq_rxc | output | 1 | Receive-ready request |
| irq_txc | output | 1 | Transmit-done request |
| irq_udre | output | 1 | Holding-buffer-free request |

## Verification
Two pairs of functions can fall in the same cycle. The first pair is the setting of transmit-done by the shifter and its clearing by a status write. The bench drives `txs_done` in the same cycle as a write of 0x40 to address 1 and expects bit 6 to read 1 afterwards. The second pair is a data-address read and an arriving character on a full receive queue. The bench issues both in one cycle, expects the old head on the bus, and then expects the new character to come out second, behind the old second entry, with no overrun flag.

// File: rtl/uart_host_pkg.sv
package uart_host_pkg;

  localparam int DW = 8;

  // Status bit positions
  localparam int ST_RXC  = 7;
  localparam int ST_TXC  = 6;
  localparam int ST_UDRE = 5;
  localparam int ST_FE   = 4;
  localparam int ST_DOR  = 3;
  localparam int ST_PE   = 2;

  typedef struct packed {
    logic [DW-1:0] data;
    logic          ferr;
    logic          perr;
    logic          ovr;
  } rx_entry_t;

  // Mask of the used data bits; size code 0..3 means 5..8 bits
  function automatic logic [DW-1:0] char_mask(input logic [1:0] size_code);
    return {DW{1'b1}} >> (2'd3 - size_code);
  endfunction

  function automatic logic [DW-1:0] pack_status(input logic rxc, input logic txc,
                                                input logic udre, input logic fe,
                                                input logic dor, input logic pe);
    logic [DW-1:0] s;
    s = '0;
    s[ST_RXC]  = rxc;
    s[ST_TXC]  = txc;
    s[ST_UDRE] = udre;
    s[ST_FE]   = fe;
    s[ST_DOR]  = dor;
    s[ST_PE]   = pe;
    return s;
  endfunction

endpackage

// File: rtl/uart_tx_hold.sv
module uart_tx_hold
  import uart_host_pkg::*;
(
  input  logic          clk,
  input  logic          rst_n,
  input  logic          wr_acc,
  input  logic [DW-1:0] wdata,
  input  logic          tx_en,
  input  logic          sh_empty,
  input  logic          sh_done,
  input  logic          txc_clr,
  output logic          udre,
  output logic          txc,
  output logic [DW-1:0] tx_buf,
  output logic          load,
  output logic          txc_set
);

  assign load    = tx_en & ~udre & sh_empty;
  assign txc_set = sh_done & udre;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      udre   <= 1'b1;
      tx_buf <= '0;
    end else if (wr_acc && udre) begin
      tx_buf <= wdata;
      udre   <= 1'b0;
    end else if (load) begin
      udre   <= 1'b1;
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n)       txc <= 1'b0;
    else if (txc_set) txc <= 1'b1;
    else if (txc_clr) txc <= 1'b0;
  end

endmodule

// File: rtl/uart_rx_fifo.sv
module uart_rx_fifo
  import uart_host_pkg::*;
#(
  parameter  int DEPTH = 2,
  localparam int PTR_W = (DEPTH > 1) ? $clog2(DEPTH) : 1,
  localparam int CNT_W = $clog2(DEPTH + 1)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             flush,
  input  logic             push,
  input  rx_entry_t        din,
  input  logic             pop_req,
  output rx_entry_t        head,
  output logic [CNT_W-1:0] count,
  output logic             overrun
);

  function automatic logic [PTR_W-1:0] step_fwd(input logic [PTR_W-1:0] p);
    return (p == PTR_W'(DEPTH - 1)) ? '0 : p + 1'b1;
  endfunction

  function automatic logic [PTR_W-1:0] step_back(input logic [PTR_W-1:0] p);
    return (p == '0) ? PTR_W'(DEPTH - 1) : p - 1'b1;
  endfunction

  rx_entry_t        slot [DEPTH];
  logic [PTR_W-1:0] wptr, rptr, newest;
  logic             pop, accept;

  assign pop     = pop_req & (count != '0);
  assign accept  = push & ((count != CNT_W'(DEPTH)) | pop);
  assign overrun = push & ~accept;
  assign newest  = step_back(wptr);
  assign head    = slot[rptr];

  for (genvar s = 0; s < DEPTH; s++) begin : g_slot
    always_ff @(posedge clk) begin
      if (!rst_n)                                   slot[s]     <= '0;
      else if (accept && wptr == PTR_W'(s))         slot[s]     <= din;
      else if (overrun && newest == PTR_W'(s))      slot[s].ovr <= 1'b1;
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n || flush) begin
      wptr  <= '0;
      rptr  <= '0;
      count <= '0;
    end else begin
      if (accept) wptr <= step_fwd(wptr);
      if (pop)    rptr <= step_fwd(rptr);
      case ({accept, pop})
        2'b10:   count <= count + 1'b1;
        2'b01:   count <= count - 1'b1;
        default: count <= count;
      endcase
    end
  end

endmodule

// File: rtl/uart_host_regs.sv
module uart_host_regs
  import uart_host_pkg::*;
#(
  parameter int RX_DEPTH = 2
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          bus_sel,
  input  logic          bus_wr,
  input  logic          bus_addr,
  input  logic [DW-1:0] bus_wdata,
  output logic [DW-1:0] bus_rdata,
  input  logic          tx_en,
  input  logic          rx_en,
  input  logic [1:0]    char_size,
  input  logic          txs_empty,
  input  logic          txs_done,
  output logic          txs_load,
  output logic [DW-1:0] txs_data,
  input  logic          rxs_valid,
  input  logic [DW-1:0] rxs_data,
  input  logic          rxs_ferr,
  input  logic          rxs_perr,
  input  logic          irq_txc_ack,
  output logic          irq_rxc,
  output logic          irq_txc,
  output logic          irq_udre
);

  localparam logic ADDR_DATA = 1'b0;
  localparam logic ADDR_STAT = 1'b1;
  localparam int   CNT_W     = $clog2(RX_DEPTH + 1);

  // Named internal events, also used by the checker
  logic             data_wr, data_rd, stat_wr;
  logic             udre, txc, txc_set, txc_clr;
  logic [DW-1:0]    tx_buf, mask;
  logic             rx_push, rx_flush, rx_ovr, rxc;
  logic [CNT_W-1:0] fifo_count;
  rx_entry_t        rx_head, rx_in;

  assign data_wr  = bus_sel &  bus_wr & (bus_addr == ADDR_DATA);
  assign data_rd  = bus_sel & ~bus_wr & (bus_addr == ADDR_DATA);
  assign stat_wr  = bus_sel &  bus_wr & (bus_addr == ADDR_STAT);
  assign txc_clr  = irq_txc_ack | (stat_wr & bus_wdata[ST_TXC]);
  assign mask     = char_mask(char_size);

  assign rx_push  = rxs_valid & rx_en;
  assign rx_flush = ~rx_en;
  assign rx_in    = '{data: rxs_data & mask, ferr: rxs_ferr, perr: rxs_perr, ovr: 1'b0};
  assign rxc      = (fifo_count != '0);

  uart_tx_hold i_tx_hold (
    .clk      (clk),
    .rst_n    (rst_n),
    .wr_acc   (data_wr),
    .wdata    (bus_wdata & mask),
    .tx_en    (tx_en),
    .sh_empty (txs_empty),
    .sh_done  (txs_done),
    .txc_clr  (txc_clr),
    .udre     (udre),
    .txc      (txc),
    .tx_buf   (tx_buf),
    .load     (txs_load),
    .txc_set  (txc_set)
  );

  uart_rx_fifo #(.DEPTH(RX_DEPTH)) i_rx_fifo (
    .clk     (clk),
    .rst_n   (rst_n),
    .flush   (rx_flush),
    .push    (rx_push),
    .din     (rx_in),
    .pop_req (data_rd),
    .head    (rx_head),
    .count   (fifo_count),
    .overrun (rx_ovr)
  );

  assign txs_data = tx_buf;

  always_comb begin
    if (bus_addr == ADDR_DATA)
      bus_rdata = rxc ? rx_head.data : '0;
    else
      bus_rdata = pack_status(rxc, txc, udre, rxc & rx_head.ferr,
                              rxc & rx_head.ovr, rxc & rx_head.perr);
  end

  assign irq_rxc  = rxc;
  assign irq_txc  = txc;
  assign irq_udre = udre;

endmodule

// File: rtl/uart_host_regs_chk.sv
module uart_host_regs_chk #(
  parameter int DEPTH = 2,
  parameter int CNT_W = 2
) (
  input logic             clk,
  input logic             rst_n,
  input logic             data_wr,
  input logic             data_rd,
  input logic             udre,
  input logic [7:0]       tx_buf,
  input logic             txs_load,
  input logic             rx_en,
  input logic             rx_push,
  input logic [CNT_W-1:0] fifo_count,
  input logic             txc_set,
  input logic             txc
);

  AST_FULL_WRITE_DROPPED: assert property (@(posedge clk) disable iff (!rst_n)
    (data_wr && !udre) |=> $stable(tx_buf)); // R2

  AST_LOAD_FREES_BUFFER: assert property (@(posedge clk) disable iff (!rst_n)
    txs_load |=> udre); // R3

  AST_FREE_ONLY_BY_LOAD: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(udre) |-> $past(txs_load)); // R3

  AST_READ_POPS: assert property (@(posedge clk) disable iff (!rst_n)
    (data_rd && fifo_count != '0 && !rx_push && rx_en)
      |=> (fifo_count == $past(fifo_count) - 1'b1)); // R4

  AST_DISABLE_FLUSHES: assert property (@(posedge clk) disable iff (!rst_n)
    !rx_en |=> (fifo_count == '0)); // R6

  AST_DONE_SETS_TXC: assert property (@(posedge clk) disable iff (!rst_n)
    txc_set |=> txc); // R7

  AST_NO_OVERFLOW: assert property (@(posedge clk) disable iff (!rst_n)
    fifo_count <= CNT_W'(DEPTH)); // R12

endmodule

bind uart_host_regs uart_host_regs_chk #(.DEPTH(RX_DEPTH), .CNT_W(CNT_W)) i_chk (
  .clk        (clk),
  .rst_n      (rst_n),
  .data_wr    (data_wr),
  .data_rd    (data_rd),
  .udre       (udre),
  .tx_buf     (tx_buf),
  .txs_load   (txs_load),
  .rx_en      (rx_en),
  .rx_push    (rx_push),
  .fifo_count (fifo_count),
  .txc_set    (txc_set),
  .txc        (txc)
);

// File: tb/test_uart_host_regs.sv
`timescale 1ns/1ps
module test_uart_host_regs;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       bus_sel = 0, bus_wr = 0, bus_addr = 0;
  logic [7:0] bus_wdata = 0, bus_rdata;
  logic       tx_en = 1, rx_en = 1;
  logic [1:0] char_size = 2'd3;
  logic       txs_empty, txs_done, txs_load;
  logic [7:0] txs_data;
  logic       rxs_valid = 0, rxs_ferr = 0, rxs_perr = 0;
  logic [7:0] rxs_data = 0;
  logic       irq_txc_ack = 0;
  logic       irq_rxc, irq_txc, irq_udre;

  always #5 clk = ~clk;

  // Shifter model: automatic, or driven by hand for collision tests
  logic       auto_sink = 1, man_empty = 1, man_done = 0;
  logic       m_empty, m_done;
  logic [2:0] m_busy;
  logic [7:0] last_tx;

  always @(posedge clk) begin
    if (!rst_n) begin
      m_empty <= 1'b1; m_done <= 1'b0; m_busy <= 3'd0; last_tx <= 8'h00;
    end else begin
      m_done <= 1'b0;
      if (auto_sink && txs_load) begin
        m_busy <= 3'd4; m_empty <= 1'b0; last_tx <= txs_data;
      end else if (m_busy != 3'd0) begin
        m_busy <= m_busy - 3'd1;
        if (m_busy == 3'd1) begin m_done <= 1'b1; m_empty <= 1'b1; end
      end
    end
  end

  assign txs_empty = auto_sink ? m_empty : man_empty;
  assign txs_done  = auto_sink ? m_done  : man_done;

  uart_host_regs i_uart_host_regs (.*);

  int applied = 0;
  int fails = 0;

  task automatic check(input string req, input logic [7:0] got, input logic [7:0] exp,
                       input string what);
    applied++;
    if (got !== exp) begin
      fails++;
      $display("FAIL %s %s got=%02h exp=%02h", req, what, got, exp);
    end
  endtask

  task automatic bwrite(input logic a, input logic [7:0] d);
    bus_sel = 1; bus_wr = 1; bus_addr = a; bus_wdata = d;
    @(negedge clk);
    bus_sel = 0; bus_wr = 0;
  endtask

  task automatic bread(input logic a, output logic [7:0] v);
    bus_sel = 1; bus_wr = 0; bus_addr = a;
    #1 v = bus_rdata;
    @(negedge clk);
    bus_sel = 0;
  endtask

  task automatic rx_push(input logic [7:0] d, input logic fe, input logic pe);
    rxs_valid = 1; rxs_data = d; rxs_ferr = fe; rxs_perr = pe;
    @(negedge clk);
    rxs_valid = 0;
  endtask

  // Vector: op[31:28] req[27:24] fl[17:16] (fe,pe) a[15:8] b[7:0]
  localparam logic [3:0] NOP = 0, WRD = 1, WRS = 2, RDD = 3, RDS = 4, RXP = 5,
                         CHKTX = 6, SIZE = 7, RXEN = 8, WAIT = 9;

  function automatic logic [31:0] mk(input logic [3:0] op, input logic [3:0] req,
                                     input logic [1:0] fl, input logic [7:0] a,
                                     input logic [7:0] b);
    return {op, req, 6'd0, fl, a, b};
  endfunction

  localparam int NV = 48;
  localparam logic [31:0] VEC [NV] = '{
    mk(RDS,   9, 0, 8'h00, 8'h20),  // R9 reset status
    mk(WRD,   1, 0, 8'hA5, 8'h00),  // R1
    mk(WAIT,  1, 0, 8'd10, 8'h00),
    mk(CHKTX, 1, 0, 8'h00, 8'hA5),  // R1
    mk(RDS,   7, 0, 8'h00, 8'h60),  // R7
    mk(WRS,   8, 0, 8'h40, 8'h00),  // R8
    mk(RDS,   8, 0, 8'h00, 8'h20),  // R8
    mk(WRD,   2, 0, 8'h11, 8'h00),  // R2
    mk(NOP,   2, 0, 8'h00, 8'h00),
    mk(WRD,   2, 0, 8'h22, 8'h00),  // R2 accepted
    mk(WRD,   2, 0, 8'h33, 8'h00),  // R2 dropped
    mk(RDS,   2, 0, 8'h00, 8'h00),  // R2 buffer full
    mk(WAIT,  2, 0, 8'd20, 8'h00),
    mk(CHKTX, 2, 0, 8'h00, 8'h22),  // R2
    mk(RDS,   7, 0, 8'h00, 8'h60),  // R7
    mk(RXP,  11, 2, 8'h3C, 8'h00),  // R11 framing error
    mk(RDS,   5, 0, 8'h00, 8'hF0),  // R5
    mk(RXP,  11, 1, 8'h81, 8'h00),  // R11 parity error
    mk(RXP,  12, 0, 8'h55, 8'h00),  // R12 third char
    mk(RDS,  12, 0, 8'h00, 8'hF0),  // R12
    mk(RDD,   4, 0, 8'h00, 8'h3C),  // R4
    mk(RDS,  12, 0, 8'h00, 8'hEC),  // R12 overrun on newer
    mk(RDD,   4, 0, 8'h00, 8'h81),  // R4
    mk(RDS,   5, 0, 8'h00, 8'h60),  // R5
    mk(RDD,   4, 0, 8'h00, 8'h00),  // R4 empty read
    mk(SIZE, 10, 0, 8'h00, 8'h00),  // R10 5 bits
    mk(RXP,  10, 0, 8'hFF, 8'h00),
    mk(RDD,  10, 0, 8'h00, 8'h1F),  // R10
    mk(WRD,  10, 0, 8'hFF, 8'h00),
    mk(WAIT, 10, 0, 8'd10, 8'h00),
    mk(CHKTX,10, 0, 8'h00, 8'h1F),  // R10
    mk(SIZE, 10, 0, 8'h03, 8'h00),
    mk(RXP,   6, 0, 8'h12, 8'h00),  // R6
    mk(RXP,   6, 0, 8'h34, 8'h00),
    mk(RXEN,  6, 0, 8'h00, 8'h00),
    mk(RXEN,  6, 0, 8'h01, 8'h00),
    mk(RDS,   6, 0, 8'h00, 8'h60),  // R6 flushed
    mk(RXEN,  6, 0, 8'h00, 8'h00),
    mk(RXP,   6, 0, 8'h77, 8'h00),  // R6 discarded
    mk(RXEN,  6, 0, 8'h01, 8'h00),
    mk(RDS,   6, 0, 8'h00, 8'h60),  // R6
    mk(RXP,   4, 0, 8'h01, 8'h00),  // R4 order
    mk(RXP,   4, 0, 8'h02, 8'h00),
    mk(RDD,   4, 0, 8'h00, 8'h01),
    mk(RXP,   4, 0, 8'h03, 8'h00),
    mk(RDD,   4, 0, 8'h00, 8'h02),
    mk(RDD,   4, 0, 8'h00, 8'h03),
    mk(RDS,   5, 0, 8'h00, 8'h60)   // R5
  };

  initial begin
    repeat (100000) @(posedge clk);
    fails++;
    $display("FAIL R0 watchdog got=hung exp=finished");
    $display("== %0d vectors applied, %0d miscompares ==", applied, fails);
    $finish;
  end

  initial begin
    logic [7:0] v;
    int loads;
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);

    for (int i = 0; i < NV; i++) begin
      logic [3:0] op;
      logic [7:0] a, b;
      string      tag;
      op  = VEC[i][31:28];
      a   = VEC[i][15:8];
      b   = VEC[i][7:0];
      tag = $sformatf("R%0d", VEC[i][27:24]);
      case (op)
        WRD:   bwrite(1'b0, a);
        WRS:   bwrite(1'b1, a);
        RDD:   begin bread(1'b0, v); check(tag, v, b, $sformatf("data vec %0d", i)); end
        RDS:   begin bread(1'b1, v); check(tag, v, b, $sformatf("status vec %0d", i)); end
        RXP:   rx_push(a, VEC[i][17], VEC[i][16]);
        CHKTX: check(tag, last_tx, b, $sformatf("shifter byte vec %0d", i));
        SIZE:  begin char_size = a[1:0]; @(negedge clk); end
        RXEN:  begin rx_en = a[0]; @(negedge clk); end
        WAIT:  repeat (a) @(negedge clk);
        default: @(negedge clk);
      endcase
    end

    // Reset state and request lines (R9, R13)
    rst_n = 0; @(negedge clk); rst_n = 1;
    bread(1'b1, v); check("R9", v, 8'h20, "status after reset");
    check("R13", {5'd0, irq_rxc, irq_txc, irq_udre}, 8'h01, "irq lines after reset");
    rx_push(8'h44, 0, 0);
    check("R13", {7'd0, irq_rxc}, 8'h01, "irq_rxc with data");
    bread(1'b0, v);
    check("R13", {7'd0, irq_rxc}, 8'h00, "irq_rxc after pop");

    // Transmitter disabled holds the byte (R3)
    tx_en = 0;
    bwrite(1'b0, 8'h5A);
    loads = 0;
    for (int k = 0; k < 3; k++) begin @(negedge clk); if (txs_load) loads++; end
    check("R3", 8'(loads), 8'h00, "loads while disabled");
    bread(1'b1, v); check("R3", v, 8'h00, "status while disabled");
    tx_en = 1;
    #1 check("R3", {7'd0, txs_load}, 8'h01, "load strobe on enable");
    check("R3", txs_data, 8'h5A, "byte at load");
    @(negedge clk);
    bread(1'b1, v); check("R3", v, 8'h20, "buffer free after load");
    repeat (10) @(negedge clk);

    // Write of 0 to bit 6 and read-only bit 5 (R8, R9)
    bwrite(1'b1, 8'hBF);
    bread(1'b1, v); check("R8", v, 8'h60, "status write without bit 6");
    irq_txc_ack = 1; @(negedge clk); irq_txc_ack = 0;
    bread(1'b1, v); check("R8", v, 8'h20, "cleared by ack");

    // Done and clear in the same cycle: set wins (R7)
    auto_sink = 0; man_empty = 1; man_done = 0;
    man_done = 1;
    bwrite(1'b1, 8'h40);
    man_done = 0;
    bread(1'b1, v); check("R7", v, 8'h60, "set beats clear");
    check("R13", {7'd0, irq_txc}, 8'h01, "irq_txc follows");

    // Done while buffer full does not set (R7)
    bwrite(1'b1, 8'h40);
    tx_en = 0;
    bwrite(1'b0, 8'h99);
    man_done = 1; @(negedge clk); man_done = 0;
    bread(1'b1, v); check("R7", v, 8'h00, "done with buffer full");
    tx_en = 1; auto_sink = 1;
    repeat (10) @(negedge clk);

    // Pop and push in one cycle on a full queue (R12)
    rx_push(8'h0A, 0, 0);
    rx_push(8'h0B, 0, 0);
    rxs_valid = 1; rxs_data = 8'h0C; rxs_ferr = 0; rxs_perr = 0;
    bread(1'b0, v);
    rxs_valid = 0;
    check("R12", v, 8'h0A, "head during simultaneous push");
    bread(1'b1, v); check("R12", v, 8'hE0, "no overrun on swap");
    bread(1'b0, v); check("R12", v, 8'h0B, "second entry");
    bread(1'b0, v); check("R12", v, 8'h0C, "kept arrival");
    bread(1'b1, v); check("R5", v, 8'h60, "empty again");

    $display("== %0d vectors applied, %0d miscompares ==", applied, fails);
    $finish;
  end

endmodule